// File: doc/BRIEF.md
# Tiled Texture Microtile Offset Generator

This block turns the position of one 64-byte microtile in a texture image into the byte offset of that microtile in memory. The image is stored in a nested tiled layout. Sixteen microtiles form a 1 KB subtile, arranged in four rows of four. Four subtiles form a 4 KB tile, so one tile covers an 8x8 block of microtiles. Tiles fill the image row by row. Even tile rows run left to right and odd tile rows run right to left. The placement of the four subtiles inside a tile depends on whether the tile row is even or odd.

A request carries the microtile column, the microtile row and the image width in microtiles. It is accepted with a valid/ready handshake. After one register stage, the response returns the offset and a flag. The flag is set when the width is not a whole number of tiles. A texture fetch or copy engine can issue one request per cycle and apply backpressure on the response side.

Top module: `tiled_offset_gen`

## Requirements
- R1: When the request width in microtiles is not a multiple of 8 (any of bits 2..0 set), the response has `rsp_misaligned`=1 and `rsp_offset`=0. Otherwise `rsp_misaligned`=0.
- R2: The low part of the offset is 64*((row mod 4)*4 + (col mod 4)). It selects the microtile inside its subtile, and bits 5..0 of an aligned offset are zero.
- R3: The subtile index is (row bit 2)*2 + (col bit 2). On an even tile row (row/8 even), index 0,1,2,3 is placed in subtile slot 0,3,1,2. The slot adds slot*1024 to the offset.
- R4: On an odd tile row, subtile index 0,1,2,3 is placed in slot 2,1,3,0. The slot adds slot*1024 to the offset.
- R5: On an even tile row, the tile term is 4096*((row/8)*(width/8) + col/8).
- R6: On an odd tile row, the tile term is 4096*((row/8)*(width/8) + width/8 - col/8 - 1), so tiles run right to left.
- R7: A request accepted on a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid`=1 after that edge. The response carries the sum of the tile, subtile and microtile terms.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, the response stays valid and its offset and flag stay unchanged. `req_ready` is 0 during this time.
- R9: When `rsp_ready` is high, `req_ready` is high. Requests presented on consecutive cycles are accepted on consecutive edges, and each response matches its own request.
- R10: After reset, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_col | input | COORD_W | Microtile column |
| req_row | input | COORD_W | Microtile row |
| req_stride | input | STRIDE_W | Image width in microtiles |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_offset | output | OFFS_W | Byte offset of the microtile |
| rsp_misaligned | output | 1 | Width was not a multiple of 8 |

## Verification
The hardest case to reach from the ports is a request that waits while a stalled response is held. A second request is presented while `rsp_ready` is low. The bench then checks two things over several cycles: the first response does not change, and the waiting request is not taken. After that, `rsp_ready` is raised, and the bench confirms that the waiting request is accepted in that same cycle and answered with its own offset. The odd-row subtile slots and the right-to-left tile order are reached with rows at 8 or above, several tiles wide. The column is chosen so that reversing the tile order moves the result away from its mirror position.

// File: rtl/tofs_pkg.sv
package tofs_pkg;
  localparam int MICRO_LG = 6;
  localparam int SUB_LG   = 10;
  localparam int TILE_LG  = 12;

  // Subtile slot for a subtile index, chosen by tile-row parity
  function automatic logic [1:0] slot_of(input logic odd_row, input logic [1:0] idx);
    logic [1:0] s;
    if (odd_row) begin
      case (idx)
        2'd0: s = 2'd2;
        2'd1: s = 2'd1;
        2'd2: s = 2'd3;
        default: s = 2'd0;
      endcase
    end else begin
      case (idx)
        2'd0: s = 2'd0;
        2'd1: s = 2'd3;
        2'd2: s = 2'd1;
        default: s = 2'd2;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/tofs_tile_term.sv
module tofs_tile_term #(
  parameter int COORD_W  = 12,
  parameter int STRIDE_W = 12,
  parameter int OFFS_W   = 31
) (
  input  logic [COORD_W-4:0]  tile_x,
  input  logic [COORD_W-4:0]  tile_y,
  input  logic [STRIDE_W-4:0] tile_stride,
  output logic [OFFS_W-1:0]   tile_term
);
  import tofs_pkg::*;

  logic [OFFS_W-1:0] x_w, y_w, s_w, eff_x, index;

  always_comb begin
    x_w = OFFS_W'(tile_x);
    y_w = OFFS_W'(tile_y);
    s_w = OFFS_W'(tile_stride);
    // odd tile rows are walked right to left
    if (tile_y[0]) eff_x = s_w - x_w - OFFS_W'(1);
    else           eff_x = x_w;
    index     = y_w * s_w + eff_x;
    tile_term = index << TILE_LG;
  end
endmodule

// File: rtl/tofs_subtile_term.sv
module tofs_subtile_term #(
  parameter int OFFS_W = 31
) (
  input  logic              odd_row,
  input  logic              row_b2,
  input  logic              col_b2,
  output logic [OFFS_W-1:0] sub_term
);
  import tofs_pkg::*;

  logic [1:0] idx, slot;

  always_comb begin
    idx      = {row_b2, col_b2};
    slot     = slot_of(odd_row, idx);
    sub_term = OFFS_W'(slot) << SUB_LG;
  end
endmodule

// File: rtl/tofs_micro_term.sv
module tofs_micro_term #(
  parameter int OFFS_W = 31
) (
  input  logic [1:0]        row_lo,
  input  logic [1:0]        col_lo,
  output logic [OFFS_W-1:0] micro_term
);
  import tofs_pkg::*;

  always_comb begin
    micro_term = OFFS_W'({row_lo, col_lo}) << MICRO_LG;
  end
endmodule

// File: rtl/tiled_offset_gen.sv
module tiled_offset_gen #(
  parameter int COORD_W  = 12,
  parameter int STRIDE_W = 12,
  parameter int OFFS_W   = COORD_W + STRIDE_W + 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [COORD_W-1:0]  req_col,
  input  logic [COORD_W-1:0]  req_row,
  input  logic [STRIDE_W-1:0] req_stride,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [OFFS_W-1:0]   rsp_offset,
  output logic                rsp_misaligned
);
  logic [OFFS_W-1:0] tile_term, sub_term, micro_term, sum;
  logic              misaligned;
  logic              accept;

  logic              valid_q, valid_d;
  logic [OFFS_W-1:0] off_q, off_d;
  logic              mis_q, mis_d;

  tofs_tile_term #(.COORD_W(COORD_W), .STRIDE_W(STRIDE_W), .OFFS_W(OFFS_W)) u_tile (
    .tile_x      (req_col[COORD_W-1:3]),
    .tile_y      (req_row[COORD_W-1:3]),
    .tile_stride (req_stride[STRIDE_W-1:3]),
    .tile_term   (tile_term)
  );

  tofs_subtile_term #(.OFFS_W(OFFS_W)) u_sub (
    .odd_row  (req_row[3]),
    .row_b2   (req_row[2]),
    .col_b2   (req_col[2]),
    .sub_term (sub_term)
  );

  tofs_micro_term #(.OFFS_W(OFFS_W)) u_micro (
    .row_lo     (req_row[1:0]),
    .col_lo     (req_col[1:0]),
    .micro_term (micro_term)
  );

  always_comb begin
    misaligned = |req_stride[2:0];
    sum        = tile_term + sub_term + micro_term;
    req_ready  = !valid_q || rsp_ready;
    accept     = req_valid && req_ready;
  end

  // next-state
  always_comb begin
    valid_d = valid_q;
    off_d   = off_q;
    mis_d   = mis_q;
    if (accept) begin
      valid_d = 1'b1;
      off_d   = misaligned ? '0 : sum;
      mis_d   = misaligned;
    end else if (rsp_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // data registers, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      mis_q <= 1'b0;
    end else if (accept) begin
      off_q <= off_d;
      mis_q <= mis_d;
    end
  end

  assign rsp_valid      = valid_q;
  assign rsp_offset     = off_q;
  assign rsp_misaligned = mis_q;
endmodule

// File: rtl/tofs_checker.sv
module tofs_checker #(
  parameter int OFFS_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [OFFS_W-1:0] rsp_offset,
  input logic              rsp_misaligned
);
  a_r1_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misaligned |-> rsp_offset == '0);

  a_r2_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_misaligned |-> rsp_offset[5:0] == 6'd0);

  a_r7_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_offset) && $stable(rsp_misaligned));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind tiled_offset_gen tofs_checker #(.OFFS_W(OFFS_W)) u_tofs_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_offset     (rsp_offset),
  .rsp_misaligned (rsp_misaligned)
);

// File: tb/tiled_offset_gen_test.sv
`timescale 1ns/1ps
module tiled_offset_gen_test;
  localparam int CW = 12;
  localparam int SW = 12;
  localparam int OW = CW + SW + 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_col = '0;
  logic [CW-1:0] req_row = '0;
  logic [SW-1:0] req_stride = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [OW-1:0] rsp_offset;
  logic          rsp_misaligned;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tiled_offset_gen #(.COORD_W(CW), .STRIDE_W(SW)) uut (.*);

  function automatic longint model(input int col, input int row, input int stride);
    int ts, tx, ty, idx, slot;
    if (stride % 8 != 0) return 0;
    ts = stride / 8; tx = col / 8; ty = row / 8;
    if (ty % 2 == 1) tx = ts - tx - 1;
    idx = ((row >> 2) & 1) * 2 + ((col >> 2) & 1);
    if (ty % 2 == 0) slot = (idx == 0) ? 0 : (idx == 1) ? 3 : (idx == 2) ? 1 : 2;
    else             slot = (idx == 0) ? 2 : (idx == 1) ? 1 : (idx == 2) ? 3 : 0;
    return 64'(4096) * (ty * ts + tx) + 1024 * slot + 64 * ((row % 4) * 4 + col % 4);
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // one request, response consumed immediately
  task automatic one_req(input string tag, input int col, input int row, input int stride);
    @(negedge clk);
    rsp_ready  = 1'b1;
    req_valid  = 1'b1;
    req_col    = CW'(col);
    req_row    = CW'(row);
    req_stride = SW'(stride);
    check({tag, " req_ready"}, longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, longint'(rsp_valid), 1);
    check({tag, " offset"}, longint'(rsp_offset), model(col, row, stride));
    check({tag, " flag"}, longint'(rsp_misaligned), (stride % 8 != 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R10 rsp_valid after reset", longint'(rsp_valid), 0);
    check("R10 req_ready after reset", longint'(req_ready), 1);
  endtask

  task automatic t_misaligned();
    one_req("R1 stride 12", 5, 9, 12);
    one_req("R1 stride 1", 0, 0, 1);
    one_req("R1 stride 7", 3, 3, 7);
    one_req("R7 stride 8 aligned", 3, 3, 8);
  endtask

  task automatic t_micro();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        one_req("R2 microtile", c, r, 16);
    one_req("R2 col3 row2", 3, 2, 8);
    check("R2 literal", longint'(rsp_offset), 64 * 11);
  endtask

  task automatic t_even_map();
    for (int i = 0; i < 4; i++)
      one_req("R3 even slot", (i & 1) * 4, (i >> 1) * 4, 16);
    one_req("R3 idx1 literal", 4, 0, 16);
    check("R3 idx1 slot3", longint'(rsp_offset), 3072);
  endtask

  task automatic t_odd_map();
    for (int i = 0; i < 4; i++)
      one_req("R4 odd slot", (i & 1) * 4, 8 + (i >> 1) * 4, 16);
    one_req("R4 literal", 0, 8, 16);
    check("R4 row8 col0 stride16", longint'(rsp_offset), 14336);
  endtask

  task automatic t_serpentine();
    for (int tx = 0; tx < 4; tx++) begin
      one_req("R5 even row tile", tx * 8 + 1, 16 + 2, 32);
      one_req("R6 odd row tile", tx * 8 + 6, 24 + 5, 32);
    end
    one_req("R6 literal", 8, 8, 32);
    check("R6 row8 col8 stride32", longint'(rsp_offset), 4096 * (4 + 2) + 2048);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_col = CW'(9); req_row = CW'(13); req_stride = SW'(24);
    @(negedge clk);
    req_col = CW'(2); req_row = CW'(4); req_stride = SW'(16);
    check("R8 first valid", longint'(rsp_valid), 1);
    check("R8 ready low", longint'(req_ready), 0);
    check("R8 first offset", longint'(rsp_offset), model(9, 13, 24));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held offset", longint'(rsp_offset), model(9, 13, 24));
      check("R8 held valid", longint'(rsp_valid), 1);
      check("R8 ready still low", longint'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    #0.1;
    check("R9 ready with rsp_ready", longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second valid", longint'(rsp_valid), 1);
    check("R8 second offset", longint'(rsp_offset), model(2, 4, 16));
    @(negedge clk);
    check("R9 drained", longint'(rsp_valid), 0);
  endtask

  task automatic t_throughput();
    int cs[5] = '{0, 15, 33, 7, 40};
    int rs[5] = '{0, 9, 30, 17, 3};
    @(negedge clk);
    rsp_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      req_valid = 1'b1; req_col = CW'(cs[i]); req_row = CW'(rs[i]); req_stride = SW'(48);
      check("R9 ready back to back", longint'(req_ready), 1);
      @(negedge clk);
      check("R9 stream valid", longint'(rsp_valid), 1);
      check("R9 stream offset", longint'(rsp_offset), model(cs[i], rs[i], 48));
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_misaligned();
    t_micro();
    t_even_map();
    t_odd_map();
    t_serpentine();
    t_backpressure();
    t_throughput();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule